// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block decides, cycle by cycle, whether a 16-bit timer counter that it contains advances, clears or starts. The decision rests on one trigger signal picked from eight sources by a 3-bit select input and on a 3-bit active mode. The counter runs up to a reload value and wraps to zero. Each wrap raises an update event. A trigger-driven clear also raises an update event.

The mode field can be written straight into the active mode. It can instead be held in a shadow register and moved into the active mode only on a transfer event. The transfer event is either the block's own update event or an external index pulse. A master/slave option holds back the effect of every trigger by one clock. With the option set, the trigger output pulse that goes to downstream timers leads this counter's reaction by exactly one cycle.

Top module: `tslave_ctrl`

## Requirements
- R1: Trigger select codes 0..3 pick `itr[0]`..`itr[3]`. Code 4 picks a both-edge pulse of `ti1`, which is high in any cycle where `ti1` differs from its value in the previous cycle. Code 5 picks `ti1f`, code 6 picks `ti2f` and code 7 picks `etrf`.
- R2: A trigger edge is a selected level that is high now and was low in the previous cycle. In the first cycle after `trig_sel` changes, no edge is reported, so `trg_out` stays low and nothing is counted.
- R3: In mode 0, and in the codes 1..3 that behave like it, `tick` equals `cnt_en`. Each tick adds one to `cnt`. A tick while `cnt == arr` sets `cnt` to 0 and raises `upd_evt` in that same cycle.
- R4: Mode 4 (reset): a trigger edge raises `cnt_rst` and `upd_evt` in the cycle of the edge, and `cnt` reads 0 in the next cycle.
- R5: Mode 5 (gated): `tick` is high only while `cnt_en` is set and the selected trigger level is high. While `tick` is low, `cnt` holds.
- R6: Mode 6 (trigger): a trigger edge sets `cnt_en` in the next cycle without clearing `cnt`. A software write through `sw_en_wr` takes priority over that set.
- R7: Mode 7 (external clock): `cnt` advances by exactly one for each rising edge of the selected trigger, however long the trigger stays high.
- R8: With `msm` set, `trg_out` pulses in the cycle of the edge, and `cnt_rst`, the count and the gate act one cycle later. With `msm` clear, they act in the same cycle as the edge.
- R9: With `preload_en` low, a mode write is visible on `active_mode` in the next cycle.
- R10: With `preload_en` high, a mode write only fills the shadow. `active_mode` takes the shadow value in the cycle after an `index_evt` pulse when `preload_src` is 1, or in the cycle after `upd_evt` when `preload_src` is 0. The other event has no effect.
- R11: After reset, `cnt` is 0, `cnt_en` is 0, `active_mode` is 0, and `tick`, `cnt_rst`, `upd_evt` and `trg_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_sel | input | 3 | Trigger source select |
| itr | input | 4 | Internal trigger lines |
| ti1 | input | 1 | Raw channel 1 input, feeds the both-edge detector |
| ti1f | input | 1 | Conditioned channel 1 input |
| ti2f | input | 1 | Conditioned channel 2 input |
| etrf | input | 1 | Conditioned external trigger |
| msm | input | 1 | Master/slave one-cycle trigger delay enable |
| sw_en_wr | input | 1 | Write strobe for the counter enable |
| sw_en_val | input | 1 | Value written to the counter enable |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 3 | Mode value written |
| preload_en | input | 1 | Route mode writes through the shadow register |
| preload_src | input | 1 | Transfer event: 0 update, 1 index |
| index_evt | input | 1 | Index pulse |
| arr | input | 16 | Reload value (top count) |
| cnt | output | 16 | Counter value |
| cnt_en | output | 1 | Counter enable state |
| active_mode | output | 3 | Mode in force |
| tick | output | 1 | Counter advances at the next edge |
| cnt_rst | output | 1 | Trigger-driven counter clear |
| upd_evt | output | 1 | Update event (wrap or trigger clear) |
| trg_out | output | 1 | Trigger pulse toward downstream timers |

## Verification
The hardest case to reach is a preloaded mode transfer driven by the block's own update event. It needs a shadow value that differs from the active one, a stray index pulse that must be ignored, and a wrap timed so the bench knows the cycle. The stimulus reads `cnt` at a falling edge, sets `arr` two counts ahead, and checks `active_mode` in the cycle of the wrap and in the cycle after it. The suppressed edge on a select change is set up by switching `trig_sel` to a source that is already high in the same cycle.

// File: rtl/tslave_ctrl.sv
module tslave_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    trig_sel,
  input  logic [3:0]    itr,
  input  logic          ti1,
  input  logic          ti1f,
  input  logic          ti2f,
  input  logic          etrf,
  input  logic          msm,
  input  logic          sw_en_wr,
  input  logic          sw_en_val,
  input  logic          mode_wr,
  input  logic [2:0]    mode_wdata,
  input  logic          preload_en,
  input  logic          preload_src,
  input  logic          index_evt,
  input  logic [CW-1:0] arr,
  output logic [CW-1:0] cnt,
  output logic          cnt_en,
  output logic [2:0]    active_mode,
  output logic          tick,
  output logic          cnt_rst,
  output logic          upd_evt,
  output logic          trg_out
);

  localparam logic [2:0] M_RESET = 3'd4;
  localparam logic [2:0] M_GATED = 3'd5;
  localparam logic [2:0] M_START = 3'd6;
  localparam logic [2:0] M_EXTCK = 3'd7;

  logic       ti1_q, prev_lvl, edge_q, lvl_q;
  logic [2:0] sel_q, shadow;
  logic       sel_lvl, edge_raw, trig_act, trig_lvl, wrap, xfer;

  wire ti1_ed = ti1 ^ ti1_q;

  always_comb begin
    case (trig_sel)
      3'd0:    sel_lvl = itr[0];
      3'd1:    sel_lvl = itr[1];
      3'd2:    sel_lvl = itr[2];
      3'd3:    sel_lvl = itr[3];
      3'd4:    sel_lvl = ti1_ed;
      3'd5:    sel_lvl = ti1f;
      3'd6:    sel_lvl = ti2f;
      default: sel_lvl = etrf;
    endcase
  end

  assign edge_raw = sel_lvl & ~prev_lvl & (trig_sel == sel_q);
  assign trig_act = msm ? edge_q : edge_raw;
  assign trig_lvl = msm ? lvl_q : sel_lvl;
  assign trg_out  = edge_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ti1_q    <= 1'b0;
      prev_lvl <= 1'b0;
      sel_q    <= 3'd0;
      edge_q   <= 1'b0;
      lvl_q    <= 1'b0;
    end else begin
      ti1_q    <= ti1;
      prev_lvl <= sel_lvl;
      sel_q    <= trig_sel;
      edge_q   <= edge_raw;
      lvl_q    <= sel_lvl;
    end
  end

  always_comb begin
    case (active_mode)
      M_GATED: tick = cnt_en & trig_lvl;
      M_EXTCK: tick = cnt_en & trig_act;
      default: tick = cnt_en;
    endcase
  end

  assign cnt_rst = (active_mode == M_RESET) & trig_act;
  assign wrap    = tick & ~cnt_rst & (cnt == arr);
  assign upd_evt = cnt_rst | wrap;
  assign xfer    = preload_src ? index_evt : upd_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (cnt_rst || wrap)
      cnt <= '0;
    else if (tick)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_en <= 1'b0;
    else if (sw_en_wr)
      cnt_en <= sw_en_val;
    else if (active_mode == M_START && trig_act)
      cnt_en <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow      <= 3'd0;
      active_mode <= 3'd0;
    end else begin
      if (mode_wr)
        shadow <= mode_wdata;
      if (mode_wr && !preload_en)
        active_mode <= mode_wdata;
      else if (preload_en && xfer)
        active_mode <= shadow;
    end
  end

endmodule

// File: rtl/tslave_ctrl_chk.sv
module tslave_ctrl_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    active_mode,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] arr,
  input logic          tick,
  input logic          cnt_rst,
  input logic          upd_evt,
  input logic          cnt_en,
  input logic          trg_out,
  input logic          trig_act,
  input logic          msm,
  input logic          sw_en_wr,
  input logic          preload_en,
  input logic          preload_src,
  input logic          index_evt,
  input logic          mode_wr
);

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> cnt == '0); // R4

  AST_CLEAR_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |-> upd_evt); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_rst) |=> $stable(cnt)); // R5

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_rst && cnt != arr) |=> cnt == CW'($past(cnt) + 1'b1)); // R3

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_rst && cnt == arr) |=> cnt == '0); // R3

  AST_START_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode == 3'd6 && trig_act && !sw_en_wr) |=> cnt_en); // R6

  AST_DELAYED_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (msm && trg_out) |=> (trig_act || !msm)); // R8

  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && preload_src && !index_evt && !mode_wr) |=> $stable(active_mode)); // R10

endmodule

bind tslave_ctrl tslave_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active_mode(active_mode), .cnt(cnt), .arr(arr),
  .tick(tick), .cnt_rst(cnt_rst), .upd_evt(upd_evt), .cnt_en(cnt_en),
  .trg_out(trg_out), .trig_act(trig_act), .msm(msm), .sw_en_wr(sw_en_wr),
  .preload_en(preload_en), .preload_src(preload_src), .index_evt(index_evt),
  .mode_wr(mode_wr)
);

// File: tb/tb_tslave_ctrl.sv
`timescale 1ns/1ps
module tb_tslave_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  trig_sel = 0;
  logic [3:0]  itr = 0;
  logic        ti1 = 0, ti1f = 0, ti2f = 0, etrf = 0, msm = 0;
  logic        sw_en_wr = 0, sw_en_val = 0, mode_wr = 0;
  logic [2:0]  mode_wdata = 0;
  logic        preload_en = 0, preload_src = 0, index_evt = 0;
  logic [15:0] arr = 16'hFFFF;
  logic [15:0] cnt;
  logic        cnt_en, tick, cnt_rst, upd_evt, trg_out;
  logic [2:0]  active_mode;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] c;

  always #2.5 clk = ~clk;

  tslave_ctrl dut (.*);

  // row: sel[10:8] itr[7:4] ti1f[3] ti2f[2] etrf[1] expected_level[0]
  localparam logic [10:0] ROWS [14] = '{
    {3'd0, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd0, 4'b1110, 1'b1, 1'b1, 1'b1, 1'b0},
    {3'd1, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd1, 4'b1101, 1'b1, 1'b1, 1'b1, 1'b0},
    {3'd2, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd3, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd3, 4'b0111, 1'b1, 1'b1, 1'b1, 1'b0},
    {3'd5, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd5, 4'b1111, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd6, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd6, 4'b1111, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd7, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b1},
    {3'd7, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd4, 4'b1111, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [2:0] m);
    @(negedge clk); mode_wr = 1; mode_wdata = m;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); sw_en_wr = 1; sw_en_val = v;
    @(negedge clk); sw_en_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1; step(1);
    check("R11 cnt", cnt, 0);
    check("R11 en", cnt_en, 0);
    check("R11 mode", active_mode, 0);
    check("R11 tick", tick, 0);
    check("R11 rst/upd", {cnt_rst, upd_evt}, 0);
    check("R11 trg", trg_out, 0);

    // R1 table in gated mode: tick shows the selected level
    wr_mode(5); set_en(1);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      {trig_sel, itr, ti1f, ti2f, etrf} = ROWS[i][10:1];
      step(2);
      check("R1 select", tick, ROWS[i][0]);
    end

    // R1 both-edge detector in external clock mode
    itr = 0; ti1f = 0; ti2f = 0; etrf = 0; trig_sel = 3'd4;
    wr_mode(7); step(2);
    c = cnt;
    @(negedge clk) ti1 = 1;
    step(1);
    @(negedge clk) ti1 = 0;
    step(2);
    check("R1 ti1 both edges", cnt, c + 2);

    // R2 select change onto a high source
    @(negedge clk); itr = 4'b0001; trig_sel = 3'd0; c = cnt;
    #1 check("R2 no edge on select change", trg_out, 0);
    step(2);
    check("R2 no count", cnt, c);
    itr = 0;

    // R3 free count and wrap
    wr_mode(0);
    @(negedge clk); c = cnt; arr = c + 3;
    step(1); check("R3 inc", cnt, c + 1);
    step(2); check("R3 top", cnt, c + 3);
    check("R3 upd at wrap", upd_evt, 1);
    step(1); check("R3 wrapped", cnt, 0);
    arr = 16'hFFFF;

    // R4 reset mode
    wr_mode(4); step(2);
    @(negedge clk) itr[0] = 1;
    #1 check("R4 clear+upd", {cnt_rst, upd_evt, trg_out}, 3'b111);
    step(1); check("R4 zero", cnt, 0);
    step(1); check("R4 runs on", cnt, 1);
    itr[0] = 0;

    // R8 delayed trigger
    msm = 1; step(3);
    @(negedge clk) itr[0] = 1;
    #1 check("R8 trg now, no clear", {trg_out, cnt_rst}, 2'b10);
    step(1); check("R8 clear one later", {trg_out, cnt_rst}, 2'b01);
    step(1); check("R8 zero", cnt, 0);
    msm = 0; itr[0] = 0; step(2);

    // R5 gated
    wr_mode(5); step(1);
    c = cnt; step(3);
    check("R5 hold while low", cnt, c);
    check("R5 tick low", tick, 0);
    @(negedge clk) itr[0] = 1; c = cnt;
    step(3); check("R5 count while high", cnt, c + 3);
    itr[0] = 0;

    // R6 trigger start
    set_en(0); wr_mode(6); step(1);
    c = cnt;
    check("R6 stopped", tick, 0);
    @(negedge clk) itr[0] = 1;
    #1 check("R6 trg, en still off", {trg_out, cnt_en}, 2'b10);
    step(1); check("R6 en set", cnt_en, 1);
    check("R6 not cleared", cnt, c);
    step(1); check("R6 counting", cnt, c + 1);
    itr[0] = 0;

    // R7 external clock
    wr_mode(7); step(1); c = cnt;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) itr[0] = 1;
      step(3);
      @(negedge clk) itr[0] = 0;
      step(1);
    end
    check("R7 one per edge", cnt, c + 3);

    // R9 direct mode write
    wr_mode(3);
    check("R9 direct", active_mode, 3);

    // R10 preload from index
    @(negedge clk); preload_en = 1; preload_src = 1;
    wr_mode(6);
    check("R10 held", active_mode, 3);
    step(2); check("R10 still held", active_mode, 3);
    @(negedge clk) index_evt = 1;
    @(negedge clk) index_evt = 0;
    check("R10 index xfer", active_mode, 6);

    // R10 preload from update, index ignored
    preload_src = 0;
    wr_mode(4);
    @(negedge clk) index_evt = 1;
    @(negedge clk) index_evt = 0;
    check("R10 index ignored", active_mode, 6);
    c = cnt; arr = c + 2;
    step(1); check("R10 before upd", active_mode, 6);
    step(1); check("R10 upd cycle", {upd_evt, active_mode}, {1'b1, 3'd6});
    step(1); check("R10 upd xfer", active_mode, 4);
    check("R10 wrap", cnt, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule